// File: doc/BRIEF.md
# Carry and Zero Flag ALU

This block is the arithmetic and logic stage of a small 16-bit processor core. Each cycle it takes the value held in the destination register, an operand word and a carry input. The operand is either a computed effective value or a word read from memory. A 3-bit function select picks one of seven operations: load, add, AND, OR, XOR, rotate-right-through-carry and add-with-carry. The result is combinational, so the core can write it back in the same cycle it presents the inputs.

The block keeps two status flags in registers, carry and zero. They change on the clock edge that closes an operation, and only when the flag-write enable is high. The surrounding core drops that enable on a store or on a failed predicate. The carry input is a separate port, so the core decides which carry the operation sees, normally the registered carry flag fed back.

The block does not form the effective address, access memory or test the predicate.

Top module: `carry_zero_alu`

## Requirements
- R1: Function code 3'b000 (load) drives the result with the operand unchanged.
- R2: Function code 3'b001 (add) drives the result with destination plus operand, modulo 2^16. With the enable high, the carry flag takes the carry out of bit 15 at the next clock edge.
- R3: Function codes 3'b010, 3'b011 and 3'b100 drive the result with the bitwise AND, OR and XOR of destination and operand.
- R4: Function code 3'b101 rotates the operand, not the destination, right by one place. The carry input enters bit 15. With the enable high, operand bit 0 becomes the carry flag at the next edge.
- R5: Function code 3'b110 (add with carry) drives the result with destination plus operand plus carry input, modulo 2^16. With the enable high, the carry flag takes the carry out of bit 15.
- R6: Load, AND, OR and XOR leave the carry flag unchanged even with the enable high.
- R7: With the enable high and any function code from 3'b000 to 3'b110, the zero flag at the next edge is 1 exactly when that cycle's 16-bit result is 0.
- R8: With the flag-write enable low, both flags keep their value across the clock edge, whatever the function.
- R9: Function code 3'b111 is reserved. The result equals the destination value and both flags keep their value.
- R10: While reset is asserted (active low), both flags read 0.
- R11: The result follows the inputs in the same cycle, with no register on the way. The flags change only on a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags update on its rising edge |
| rstN | input | 1 | Active-low reset that clears both flags |
| funcSel | input | 3 | Operation select, codes as in R1–R9 |
| dstVal | input | 16 | Current destination register value |
| opVal | input | 16 | Operand: effective value or memory word |
| carryIn | input | 1 | Carry seen by add-with-carry and rotate |
| flagWrEn | input | 1 | High to let this operation update the flags |
| result | output | 16 | Operation result, combinational |
| carryFlag | output | 1 | Registered carry flag |
| zeroFlag | output | 1 | Registered zero flag |

## Verification
The only internal state in this block is the two flag bits. A wrong flag, or one that should have held but moved, shows on carryFlag or zeroFlag one clock edge after the operation that caused it. The bench therefore compares both flags after every edge with a model that tracks what they should hold. A fault in operation decoding or in the datapath shows on the result port in the same cycle as the inputs. Checking the result before each edge pins such a fault to the exact function code and operands that exposed it.

// File: rtl/czalu_pkg.sv
package czalu_pkg;

  typedef enum logic [2:0] {
    FN_LOAD = 3'b000,
    FN_ADD  = 3'b001,
    FN_AND  = 3'b010,
    FN_OR   = 3'b011,
    FN_XOR  = 3'b100,
    FN_ROR  = 3'b101,
    FN_ADC  = 3'b110,
    FN_RSVD = 3'b111
  } aluFunc_e;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic selPass;   // result = operand
    logic selAdd;    // result = sum
    logic useCin;    // add the carry input into the sum
    logic selAnd;
    logic selOr;
    logic selXor;
    logic selRor;
    logic selHold;   // result = destination (reserved code)
    logic updCarry;  // load carry flag this edge
    logic updZero;   // load zero flag this edge
  } aluStrobes_t;

endpackage

// File: rtl/czalu_control.sv
module czalu_control
  import czalu_pkg::*;
(
  input  logic [2:0]  funcSel,
  input  logic        flagWrEn,
  output aluStrobes_t strobes
);

  aluFunc_e fn;
  assign fn = aluFunc_e'(funcSel);

  always_comb begin
    strobes = '0;
    case (fn)
      FN_LOAD: begin
        strobes.selPass = 1'b1;
        strobes.updZero = flagWrEn;
      end
      FN_ADD: begin
        strobes.selAdd   = 1'b1;
        strobes.updCarry = flagWrEn;
        strobes.updZero  = flagWrEn;
      end
      FN_AND: begin
        strobes.selAnd  = 1'b1;
        strobes.updZero = flagWrEn;
      end
      FN_OR: begin
        strobes.selOr   = 1'b1;
        strobes.updZero = flagWrEn;
      end
      FN_XOR: begin
        strobes.selXor  = 1'b1;
        strobes.updZero = flagWrEn;
      end
      FN_ROR: begin
        strobes.selRor   = 1'b1;
        strobes.updCarry = flagWrEn;
        strobes.updZero  = flagWrEn;
      end
      FN_ADC: begin
        strobes.selAdd   = 1'b1;
        strobes.useCin   = 1'b1;
        strobes.updCarry = flagWrEn;
        strobes.updZero  = flagWrEn;
      end
      default: begin
        strobes.selHold = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/czalu_datapath.sv
module czalu_datapath
  import czalu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluStrobes_t      strobes,
  input  logic [WIDTH-1:0] dstVal,
  input  logic [WIDTH-1:0] opVal,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryFlag,
  output logic             zeroFlag
);

  localparam int SUMW = WIDTH + 1;

  logic [SUMW-1:0]  sumExt;
  logic [SUMW-1:0]  cinExt;
  logic [WIDTH-1:0] rorVal;
  logic             carryNext;
  logic             resIsZero;

  // Single adder shared by add and add-with-carry
  assign cinExt = {{WIDTH{1'b0}}, strobes.useCin & carryIn};
  assign sumExt = {1'b0, dstVal} + {1'b0, opVal} + cinExt;

  // Rotate acts on the operand through the incoming carry
  assign rorVal = {carryIn, opVal[WIDTH-1:1]};

  always_comb begin
    if (strobes.selAdd)       result = sumExt[WIDTH-1:0];
    else if (strobes.selAnd)  result = dstVal & opVal;
    else if (strobes.selOr)   result = dstVal | opVal;
    else if (strobes.selXor)  result = dstVal ^ opVal;
    else if (strobes.selRor)  result = rorVal;
    else if (strobes.selPass) result = opVal;
    else                      result = dstVal;
  end

  assign carryNext = strobes.selRor ? opVal[0] : sumExt[WIDTH];
  assign resIsZero = (result == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryFlag <= 1'b0;
      zeroFlag  <= 1'b0;
    end else begin
      if (strobes.updCarry) carryFlag <= carryNext;
      if (strobes.updZero)  zeroFlag  <= resIsZero;
    end
  end

endmodule

// File: rtl/carry_zero_alu.sv
module carry_zero_alu
  import czalu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       funcSel,
  input  logic [WIDTH-1:0] dstVal,
  input  logic [WIDTH-1:0] opVal,
  input  logic             carryIn,
  input  logic             flagWrEn,
  output logic [WIDTH-1:0] result,
  output logic             carryFlag,
  output logic             zeroFlag
);

  aluStrobes_t strobes;

  czalu_control uCtrl (
    .funcSel  (funcSel),
    .flagWrEn (flagWrEn),
    .strobes  (strobes)
  );

  czalu_datapath #(.WIDTH(WIDTH)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dstVal    (dstVal),
    .opVal     (opVal),
    .carryIn   (carryIn),
    .result    (result),
    .carryFlag (carryFlag),
    .zeroFlag  (zeroFlag)
  );

endmodule

// File: rtl/czalu_chk.sv
module czalu_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       funcSel,
  input logic [WIDTH-1:0] dstVal,
  input logic [WIDTH-1:0] opVal,
  input logic             carryIn,
  input logic             flagWrEn,
  input logic [WIDTH-1:0] result,
  input logic             carryFlag,
  input logic             zeroFlag
);

  // R8
  hold_when_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flagWrEn |=> ($stable(carryFlag) && $stable(zeroFlag)));

  // R6
  logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (funcSel == 3'b000 || funcSel == 3'b010 || funcSel == 3'b011 || funcSel == 3'b100)
    |=> $stable(carryFlag));

  // R7
  zero_tracks_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagWrEn && funcSel != 3'b111) |=> (zeroFlag == ($past(result) == '0)));

  // R4
  ror_carry_from_lsb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagWrEn && funcSel == 3'b101) |=> (carryFlag == $past(opVal[0])));

  // R4
  ror_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (funcSel == 3'b101) |-> (result == {carryIn, opVal[WIDTH-1:1]}));

  // R9
  reserved_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (funcSel == 3'b111) |=> ($stable(carryFlag) && $stable(zeroFlag)));

  // R10
  always_comb begin
    if (!rstN) begin
      reset_clears_chk: assert (!carryFlag && !zeroFlag);
    end
  end

endmodule

bind carry_zero_alu czalu_chk #(.WIDTH(WIDTH)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .funcSel   (funcSel),
  .dstVal    (dstVal),
  .opVal     (opVal),
  .carryIn   (carryIn),
  .flagWrEn  (flagWrEn),
  .result    (result),
  .carryFlag (carryFlag),
  .zeroFlag  (zeroFlag)
);

// File: tb/sim_carry_zero_alu.sv
module sim_carry_zero_alu;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  funcSel = '0;
  logic [15:0] dstVal = '0;
  logic [15:0] opVal = '0;
  logic        carryIn = 1'b0;
  logic        flagWrEn = 1'b0;
  logic [15:0] result;
  logic        carryFlag;
  logic        zeroFlag;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  logic mC = 1'b0;
  logic mZ = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  carry_zero_alu u0 (
    .clk(clk), .rstN(rstN), .funcSel(funcSel), .dstVal(dstVal), .opVal(opVal),
    .carryIn(carryIn), .flagWrEn(flagWrEn), .result(result),
    .carryFlag(carryFlag), .zeroFlag(zeroFlag)
  );

  function automatic logic [16:0] refCalc(input logic [2:0] f, input logic [15:0] d,
                                          input logic [15:0] o, input logic ci);
    logic [16:0] s;
    case (f)
      3'b000: s = {1'b0, o};
      3'b001: s = {1'b0, d} + {1'b0, o};
      3'b010: s = {1'b0, d & o};
      3'b011: s = {1'b0, d | o};
      3'b100: s = {1'b0, d ^ o};
      3'b101: s = {o[0], ci, o[15:1]};
      3'b110: s = {1'b0, d} + {1'b0, o} + {16'd0, ci};
      default: s = {1'b0, d};
    endcase
    return s;
  endfunction

  function automatic string reqOf(input logic [2:0] f);
    case (f)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010, 3'b011, 3'b100: return "R3";
      3'b101: return "R4";
      3'b110: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
    end
  endtask

  task automatic doOp(input logic [2:0] f, input logic [15:0] d, input logic [15:0] o,
                      input logic ci, input logic we);
    logic [16:0] r;
    logic nC, nZ;
    string cReq, zReq;
    @(negedge clk);
    funcSel = f; dstVal = d; opVal = o; carryIn = ci; flagWrEn = we;
    r = refCalc(f, d, o, ci);
    #1;
    // R11: result present in the same cycle
    check({reqOf(f), "/R11"}, "result", result, r[15:0]);
    nC = mC; nZ = mZ;
    cReq = "R8"; zReq = "R8";
    if (we && f != 3'b111) begin
      nZ = (r[15:0] == 16'd0); zReq = "R7";
      if (f == 3'b001 || f == 3'b101 || f == 3'b110) begin
        nC = r[16]; cReq = reqOf(f);
      end else begin
        cReq = "R6";
      end
    end else if (f == 3'b111) begin
      cReq = "R9"; zReq = "R9";
    end
    // R11: flags unchanged before the edge
    check("R11", "carry pre-edge", {15'd0, carryFlag}, {15'd0, mC});
    @(posedge clk);
    #1;
    check(cReq, "carryFlag", {15'd0, carryFlag}, {15'd0, nC});
    check(zReq, "zeroFlag", {15'd0, zeroFlag}, {15'd0, nZ});
    mC = nC; mZ = nZ;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    // R10: flags cleared in reset
    check("R10", "carry in reset", {15'd0, carryFlag}, 16'd0);
    check("R10", "zero in reset", {15'd0, zeroFlag}, 16'd0);
    @(negedge clk);
    rstN = 1'b1;

    // Directed corners
    doOp(3'b001, 16'hFFFF, 16'h0001, 1'b0, 1'b1);  // R2: wraps to 0, carry 1, zero 1
    doOp(3'b010, 16'hF0F0, 16'h0F0F, 1'b0, 1'b1);  // R6: carry stays 1, zero 1
    doOp(3'b101, 16'h1234, 16'h0001, 1'b0, 1'b1);  // R4: result 0, carry 1
    doOp(3'b101, 16'hAAAA, 16'h8000, 1'b1, 1'b1);  // R4: carry in enters bit 15
    doOp(3'b110, 16'h7FFF, 16'h0000, 1'b1, 1'b1);  // R5
    doOp(3'b110, 16'hFFFF, 16'h0000, 1'b1, 1'b1);  // R5: carry out via cin
    doOp(3'b001, 16'h8000, 16'h8000, 1'b0, 1'b0);  // R8: flags held
    doOp(3'b111, 16'h0000, 16'h5555, 1'b1, 1'b1);  // R9: reserved
    doOp(3'b000, 16'hBEEF, 16'h0000, 1'b1, 1'b1);  // R1 / R7
    doOp(3'b011, 16'h0000, 16'h0000, 1'b0, 1'b1);  // R3
    doOp(3'b100, 16'hA5A5, 16'hA5A5, 1'b0, 1'b1);  // R3

    // Constrained random
    for (int i = 0; i < 600; i++) begin
      logic [2:0]  f;
      logic [15:0] d, o;
      logic        ci, we;
      f  = 3'($urandom);
      d  = 16'($urandom);
      o  = ($urandom % 8 == 0) ? 16'd0 : 16'($urandom);
      if ($urandom % 8 == 0) d = 16'hFFFF - o + 16'(($urandom % 2));
      ci = 1'($urandom);
      we = ($urandom % 4 != 0);
      doOp(f, d, o, ci, we);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule